// File: doc/BRIEF.md
# Double-Buffered USB Host OUT Pipe Transmit Buffer

This block manages the transmit storage of one host-side OUT pipe. It holds one or two banks of bytes. Firmware owns one bank at a time, fills it through a byte write port, and then gives it up by clearing a FIFO-control flag. The bus-side sender drains the banks in the order they were handed over and pulses a done strobe when each has been transmitted. That bank then returns to software.

Two flags tell software that it owns a free bank: a transmit-ready flag, which can raise an interrupt and is acknowledged on its own, and the FIFO-control flag, which marks bank ownership. Both are raised together. Clearing the FIFO-control flag while the transmit-ready flag is still set is a sequencing error. That request is refused and recorded in a sticky bit. When the host has stopped generating start-of-frame packets while a bank is waiting, the block asks the controller to wake up so the data can go out.

Top module: `outPipeBuf`

## Requirements
- R1: While `cfgDone` is 0 all pipe state is cleared on each clock edge: flags, sticky error, bank pointers and byte counts. While `freeze` is 1, writes, releases, acknowledges, sent strobes and flag raising have no effect, and `busPending` is 0.
- R2: On an active pipe with `fifoCtl` at 0 and the software bank (`swBank`) not handed off, `readyFlag` and `fifoCtl` both become 1 on the next clock edge, in the same cycle.
- R3: `pipeIrq` is 1 exactly when `readyFlag` is 1 and `irqEnable` is 1.
- R4: A cycle with `ackReady` at 1 clears `readyFlag` at the next edge. It leaves `fifoCtl`, `swBank` and the bank contents unchanged.
- R5: A `wrValid` cycle with `fifoCtl` at 1 and room in the bank stores `wrByte` at the next free offset of the software bank (offsets 0 upward) and adds one to its count. Writes when `fifoCtl` is 0 or the bank holds `BANK_BYTES` bytes are ignored.
- R6: `roomLeft` is 1 exactly when `fifoCtl` is 1 and the software bank holds fewer than `BANK_BYTES` bytes.
- R7: A `releaseBank` cycle with `fifoCtl` at 1 and `readyFlag` at 0 hands the bank to the bus side and clears `fifoCtl`. With two banks `swBank` toggles; with one it stays 0. The flags are raised again one edge later only if the new software bank is free.
- R8: A `releaseBank` cycle while `readyFlag` is 1 is ignored (`fifoCtl` and `swBank` unchanged) and sets `seqError`. `seqError` stays set until `cfgDone` goes to 0.
- R9: `busPending` is 1 while the bank at `busBank` has been handed off. `busLen` gives that bank's byte count and `busRdData` gives its byte at offset `busRdAddr`. Banks are offered in hand-off order.
- R10: A `busSent` cycle while `busPending` is 1 frees that bank, clears its count and advances `busBank`. If the freed bank is the software bank, the flags rise on the following edge.
- R11: `wakeReq` is 1 exactly when `sofEnable` is 0 and `busPending` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgDone | input | 1 | Pipe configured; 0 clears the pipe |
| freeze | input | 1 | Pipe frozen; holds all state |
| sofEnable | input | 1 | Start-of-frame generation on; 0 means suspend |
| irqEnable | input | 1 | Interrupt enable for the transmit-ready flag |
| ackReady | input | 1 | Acknowledge strobe that clears the transmit-ready flag |
| releaseBank | input | 1 | Request to clear the FIFO-control flag |
| wrValid | input | 1 | Byte write strobe |
| wrByte | input | 8 | Byte to write |
| busSent | input | 1 | Bus side has finished sending the offered bank |
| busRdAddr | input | ADDR_W | Byte offset read by the bus side |
| readyFlag | output | 1 | Transmit-ready interrupt flag |
| fifoCtl | output | 1 | Software owns a free bank |
| roomLeft | output | 1 | Software bank not full |
| seqError | output | 1 | Sticky: release attempted before acknowledge |
| pipeIrq | output | 1 | Pipe interrupt request |
| wakeReq | output | 1 | Request to leave suspend |
| swBank | output | 1 | Software bank pointer |
| busBank | output | 1 | Bus bank pointer |
| busPending | output | 1 | A handed-off bank waits at `busBank` |
| busLen | output | CNT_W | Byte count of the offered bank |
| busRdData | output | 8 | Byte of the offered bank at `busRdAddr` |

## Verification
The bench uses four-byte banks. It fills and sends every length from empty to full twice, so each bank sees each length. Each byte is read back against a computed pattern. A design with an off-by-one count would either accept a fifth byte or report a wrong length. A design that skips the bank toggle would return the wrong bank's data.

Further cases:
- Both banks are handed off before either is sent. A design that raises the flags on a full bank, or that drains out of order, fails this case.
- A release is tried before the acknowledge. A design that obeys that release would switch banks and leave `seqError` low.
- Writes and releases are applied while frozen. A design that does not hold its state when frozen gets a wrong length afterwards.
- Suspend is entered with a bank pending. A design without the wake logic never asks to resume.

// File: rtl/outPipePkg.sv
package outPipePkg;

  // Strobes from the bank controller to the byte store.
  typedef struct packed {
    logic wrEn;      // store one byte into the software bank
    logic wrBank;    // bank that takes the byte
    logic freeEn;    // a bank has been sent: clear its count
    logic freeBank;  // bank being freed
    logic flush;     // pipe unconfigured: clear every count
  } dpStrobe_t;

endpackage

// File: rtl/outPipeData.sv
module outPipeData
  import outPipePkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = $clog2(BANK_BYTES),
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        wrByte,
  input  logic              swBank,
  input  logic              busBank,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  swCount,
  output logic [CNT_W-1:0]  busCount,
  output logic [7:0]        rdData
);

  logic [CNT_W-1:0] countArr [NUM_BANKS];
  logic [7:0]       readArr  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic BIDX = 1'(b);
    logic [7:0]       store [BANK_BYTES];
    logic [CNT_W-1:0] cnt;
    logic             hit;
    logic             clear;

    assign hit   = strobe.wrEn && (strobe.wrBank == BIDX);
    assign clear = strobe.flush || (strobe.freeEn && (strobe.freeBank == BIDX));

    // Byte storage carries no reset; the count decides what is valid.
    always_ff @(posedge clk) begin
      if (hit) store[cnt[ADDR_W-1:0]] <= wrByte;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      cnt <= '0;
      else if (clear) cnt <= '0;
      else if (hit)   cnt <= cnt + 1'b1;
    end

    assign countArr[b] = cnt;
    assign readArr[b]  = store[rdAddr];
  end

  assign swCount  = countArr[swBank];
  assign busCount = countArr[busBank];
  assign rdData   = readArr[busBank];

endmodule

// File: rtl/outPipeCtrl.sv
module outPipeCtrl
  import outPipePkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int NUM_BANKS  = 2,
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgDone,
  input  logic             freeze,
  input  logic             ackReady,
  input  logic             releaseBank,
  input  logic             wrValid,
  input  logic             busSent,
  input  logic [CNT_W-1:0] swCount,
  output dpStrobe_t        strobe,
  output logic             readyFlag,
  output logic             fifoCtl,
  output logic             seqError,
  output logic             swBank,
  output logic             busBank,
  output logic             busPending,
  output logic             roomLeft
);

  localparam logic TWO_BANKS = (NUM_BANKS == 2);

  logic [NUM_BANKS-1:0] held;  // bank handed to the bus side
  logic active, bankRoom, wrOk, relOk, relBad, sentOk, raise;
  logic nextSw, nextBus;

  assign active   = cfgDone && !freeze;
  assign bankRoom = (swCount != CNT_W'(BANK_BYTES));
  assign wrOk     = active && fifoCtl && wrValid && bankRoom;
  assign relOk    = active && fifoCtl && releaseBank && !readyFlag;
  assign relBad   = active && releaseBank && readyFlag;
  assign busPending = active && held[busBank];
  assign sentOk   = busSent && busPending;
  assign raise    = active && !fifoCtl && !held[swBank];
  assign nextSw   = TWO_BANKS ? ~swBank  : 1'b0;
  assign nextBus  = TWO_BANKS ? ~busBank : 1'b0;
  assign roomLeft = fifoCtl && bankRoom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyFlag <= 1'b0;
      fifoCtl   <= 1'b0;
      seqError  <= 1'b0;
      swBank    <= 1'b0;
      busBank   <= 1'b0;
      held      <= '0;
    end else if (!cfgDone) begin
      readyFlag <= 1'b0;
      fifoCtl   <= 1'b0;
      seqError  <= 1'b0;
      swBank    <= 1'b0;
      busBank   <= 1'b0;
      held      <= '0;
    end else if (active) begin
      if (raise) begin
        readyFlag <= 1'b1;
        fifoCtl   <= 1'b1;
      end else if (ackReady) begin
        readyFlag <= 1'b0;
      end
      if (relOk) begin
        fifoCtl      <= 1'b0;
        held[swBank] <= 1'b1;
        swBank       <= nextSw;
      end
      if (relBad) seqError <= 1'b1;
      if (sentOk) begin
        held[busBank] <= 1'b0;
        busBank       <= nextBus;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrEn     = wrOk;
    strobe.wrBank   = swBank;
    strobe.freeEn   = sentOk;
    strobe.freeBank = busBank;
    strobe.flush    = !cfgDone;
  end

endmodule

// File: rtl/outPipeBuf.sv
module outPipeBuf
  import outPipePkg::*;
#(
  parameter  int BANK_BYTES = 64,
  parameter  int NUM_BANKS  = 2,
  localparam int ADDR_W     = $clog2(BANK_BYTES),
  localparam int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDone,
  input  logic              freeze,
  input  logic              sofEnable,
  input  logic              irqEnable,
  input  logic              ackReady,
  input  logic              releaseBank,
  input  logic              wrValid,
  input  logic [7:0]        wrByte,
  input  logic              busSent,
  input  logic [ADDR_W-1:0] busRdAddr,
  output logic              readyFlag,
  output logic              fifoCtl,
  output logic              roomLeft,
  output logic              seqError,
  output logic              pipeIrq,
  output logic              wakeReq,
  output logic              swBank,
  output logic              busBank,
  output logic              busPending,
  output logic [CNT_W-1:0]  busLen,
  output logic [7:0]        busRdData
);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] swCount;

  outPipeCtrl #(.BANK_BYTES(BANK_BYTES), .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .cfgDone(cfgDone), .freeze(freeze),
    .ackReady(ackReady), .releaseBank(releaseBank), .wrValid(wrValid),
    .busSent(busSent), .swCount(swCount), .strobe(strobe),
    .readyFlag(readyFlag), .fifoCtl(fifoCtl), .seqError(seqError),
    .swBank(swBank), .busBank(busBank), .busPending(busPending),
    .roomLeft(roomLeft)
  );

  outPipeData #(.BANK_BYTES(BANK_BYTES), .NUM_BANKS(NUM_BANKS),
                .ADDR_W(ADDR_W), .CNT_W(CNT_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(wrByte),
    .swBank(swBank), .busBank(busBank), .rdAddr(busRdAddr),
    .swCount(swCount), .busCount(busLen), .rdData(busRdData)
  );

  assign pipeIrq = readyFlag && irqEnable;
  assign wakeReq = !sofEnable && busPending;

endmodule

// File: rtl/outPipeChecker.sv
module outPipeChecker #(
  parameter int BANK_BYTES = 64,
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgDone,
  input logic             freeze,
  input logic             sofEnable,
  input logic             ackReady,
  input logic             releaseBank,
  input logic             readyFlag,
  input logic             fifoCtl,
  input logic             roomLeft,
  input logic             seqError,
  input logic             pipeIrq,
  input logic             wakeReq,
  input logic             swBank,
  input logic             busBank,
  input logic             busPending,
  input logic [CNT_W-1:0] busLen
);

  logic active;
  assign active = cfgDone && !freeze;

  assert_cleared_when_unconfigured_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDone |=> (!readyFlag && !fifoCtl && !seqError));

  assert_frozen_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDone && freeze) |=> ($stable(fifoCtl) && $stable(swBank) && $stable(busBank)));

  assert_flags_rise_together_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyFlag) |-> $rose(fifoCtl));

  assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    pipeIrq |-> readyFlag);

  assert_ack_keeps_bank_R4: assert property (@(posedge clk) disable iff (!rstN)
    (active && ackReady && readyFlag) |=> (!readyFlag && fifoCtl && $stable(swBank)));

  assert_room_needs_owner_R6: assert property (@(posedge clk) disable iff (!rstN)
    roomLeft |-> fifoCtl);

  assert_early_release_refused_R8: assert property (@(posedge clk) disable iff (!rstN)
    (active && releaseBank && readyFlag) |=> (seqError && fifoCtl && $stable(swBank)));

  assert_len_bounded_R9: assert property (@(posedge clk) disable iff (!rstN)
    busLen <= CNT_W'(BANK_BYTES));

  assert_wake_only_when_pending_R11: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (busPending && !sofEnable));

endmodule

bind outPipeBuf outPipeChecker #(.BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W)) checks (
  .clk(clk), .rstN(rstN), .cfgDone(cfgDone), .freeze(freeze), .sofEnable(sofEnable),
  .ackReady(ackReady), .releaseBank(releaseBank), .readyFlag(readyFlag),
  .fifoCtl(fifoCtl), .roomLeft(roomLeft), .seqError(seqError), .pipeIrq(pipeIrq),
  .wakeReq(wakeReq), .swBank(swBank), .busBank(busBank), .busPending(busPending),
  .busLen(busLen)
);

// File: tb/outPipeBuf_test.sv
`timescale 1ns/1ps
module outPipeBuf_test;

  localparam int BB = 4;
  localparam int AW = $clog2(BB);
  localparam int CW = $clog2(BB + 1);

  logic clk = 1'b0;
  logic rstN, cfgDone, freeze, sofEnable, irqEnable, ackReady, releaseBank;
  logic wrValid, busSent;
  logic [7:0] wrByte;
  logic [AW-1:0] busRdAddr;
  logic readyFlag, fifoCtl, roomLeft, seqError, pipeIrq, wakeReq;
  logic swBank, busBank, busPending;
  logic [CW-1:0] busLen;
  logic [7:0] busRdData;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  outPipeBuf #(.BANK_BYTES(BB), .NUM_BANKS(2)) uut (
    .clk(clk), .rstN(rstN), .cfgDone(cfgDone), .freeze(freeze), .sofEnable(sofEnable),
    .irqEnable(irqEnable), .ackReady(ackReady), .releaseBank(releaseBank),
    .wrValid(wrValid), .wrByte(wrByte), .busSent(busSent), .busRdAddr(busRdAddr),
    .readyFlag(readyFlag), .fifoCtl(fifoCtl), .roomLeft(roomLeft), .seqError(seqError),
    .pipeIrq(pipeIrq), .wakeReq(wakeReq), .swBank(swBank), .busBank(busBank),
    .busPending(busPending), .busLen(busLen), .busRdData(busRdData)
  );

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Advance one edge; inputs change and outputs are sampled 1 ns after it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulseAck();
    ackReady = 1'b1; tick(); ackReady = 1'b0;
  endtask

  task automatic pulseRelease();
    releaseBank = 1'b1; tick(); releaseBank = 1'b0;
  endtask

  task automatic pulseSent();
    busSent = 1'b1; tick(); busSent = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] v);
    wrByte = v; wrValid = 1'b1; tick(); wrValid = 1'b0;
  endtask

  function automatic logic [7:0] pat(int lap, int i);
    return 8'((lap * 37 + i * 11 + 5) & 255);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int expSw;
    int expBus;
    rstN = 1'b0; cfgDone = 1'b0; freeze = 1'b0; sofEnable = 1'b1; irqEnable = 1'b0;
    ackReady = 1'b0; releaseBank = 1'b0; wrValid = 1'b0; busSent = 1'b0;
    wrByte = '0; busRdAddr = '0;
    repeat (3) tick();
    chk("R1 reset readyFlag", readyFlag, 0);
    chk("R1 reset fifoCtl", fifoCtl, 0);
    chk("R1 reset busPending", busPending, 0);
    rstN = 1'b1; tick();
    chk("R1 unconfigured no flag", fifoCtl, 0);
    cfgDone = 1'b1; freeze = 1'b1; tick(); tick();
    chk("R1 frozen no flag", readyFlag, 0);
    freeze = 1'b0; tick();
    chk("R2 readyFlag raised", readyFlag, 1);
    chk("R2 fifoCtl raised", fifoCtl, 1);
    chk("R6 roomLeft empty bank", roomLeft, 1);
    chk("R3 irq masked", pipeIrq, 0);
    irqEnable = 1'b1; #1;
    chk("R3 irq enabled", pipeIrq, 1);

    // Release before acknowledge is refused.
    pulseRelease();
    chk("R8 fifoCtl kept", fifoCtl, 1);
    chk("R8 seqError set", seqError, 1);
    chk("R8 swBank kept", swBank, 0);
    chk("R8 nothing pending", busPending, 0);

    pulseAck();
    chk("R4 readyFlag cleared", readyFlag, 0);
    chk("R4 fifoCtl kept", fifoCtl, 1);
    chk("R4 swBank kept", swBank, 0);
    chk("R3 irq follows flag", pipeIrq, 0);

    // Every length from empty to full, twice, alternating banks.
    expSw = 0; expBus = 0;
    for (int lap = 0; lap < 2 * (BB + 1); lap++) begin
      int n = lap % (BB + 1);
      for (int i = 0; i < n; i++) begin
        writeByte(pat(lap, i));
        chk("R6 roomLeft after write", roomLeft, (i + 1 < BB) ? 1 : 0);
      end
      if (n == BB) begin
        writeByte(8'hEE);
        chk("R5 write to full bank ignored, roomLeft", roomLeft, 0);
      end
      pulseRelease();
      chk("R7 fifoCtl cleared", fifoCtl, 0);
      chk("R7 swBank toggled", swBank, expSw ^ 1);
      chk("R9 busPending", busPending, 1);
      chk("R9 busBank", busBank, expBus);
      expSw ^= 1;
      tick();
      chk("R7 flags back on free bank", readyFlag, 1);
      chk("R7 fifoCtl back on free bank", fifoCtl, 1);
      chk("R5 R9 busLen", busLen, n);
      for (int a = 0; a < n; a++) begin
        busRdAddr = AW'(a); #1;
        chk("R5 R9 stored byte", busRdData, pat(lap, a));
      end
      pulseSent();
      chk("R10 bank freed", busPending, 0);
      chk("R10 busBank advanced", busBank, expBus ^ 1);
      expBus ^= 1;
      pulseAck();
    end

    // Both banks handed off before any is sent.
    for (int i = 0; i < 3; i++) writeByte(8'hA0 + 8'(i));
    pulseRelease();
    tick();
    chk("R7 other bank free", fifoCtl, 1);
    pulseAck();
    for (int i = 0; i < 2; i++) writeByte(8'hB0 + 8'(i));
    pulseRelease();
    chk("R7 swBank back to first", swBank, expSw);
    tick();
    chk("R7 no flags on held bank", fifoCtl, 0);
    chk("R7 no ready on held bank", readyFlag, 0);
    chk("R9 first bank offered", busLen, 3);
    busRdAddr = '0; #1;
    chk("R9 first bank data", busRdData, 8'hA0);
    pulseSent();
    chk("R9 second bank pending", busPending, 1);
    chk("R9 second bank length", busLen, 2);
    busRdAddr = AW'(1); #1;
    chk("R9 second bank data", busRdData, 8'hB1);
    chk("R10 flags not yet", readyFlag, 0);
    tick();
    chk("R10 ready after free", readyFlag, 1);
    chk("R10 fifoCtl after free", fifoCtl, 1);
    sofEnable = 1'b0; #1;
    chk("R11 wake when pending in suspend", wakeReq, 1);
    pulseSent();
    chk("R11 no wake when idle", wakeReq, 0);
    sofEnable = 1'b1;

    // Frozen pipe ignores writes and releases.
    pulseAck();
    writeByte(8'h55);
    freeze = 1'b1;
    writeByte(8'h66);
    pulseRelease();
    chk("R1 frozen release ignored", fifoCtl, 1);
    chk("R1 frozen not pending", busPending, 0);
    freeze = 1'b0;
    pulseRelease();
    chk("R1 frozen write ignored", busLen, 1);
    busRdAddr = '0; #1;
    chk("R5 byte before freeze", busRdData, 8'h55);
    chk("R8 seqError sticky", seqError, 1);

    cfgDone = 1'b0; tick();
    chk("R1 deconfigure flag", fifoCtl, 0);
    chk("R1 deconfigure pending", busPending, 0);
    chk("R1 deconfigure seqError", seqError, 0);
    chk("R1 deconfigure swBank", swBank, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule